// File: doc/BRIEF.md
# SMI Event Status Register

This block collects the causes of a system-management interrupt into one 16-bit status word. Nine hardware sources each deliver a one-cycle pulse: legacy keyboard emulation, a power-management control write, an external SMI pin, an internal fast-off timer, and the IRQ12, IRQ8 (active low), IRQ4, IRQ3 and IRQ1 request lines. Each pulse sets a sticky bit. A bit stays set until software clears it by writing a 0 to its position over a small synchronous register bus. A separate enable mask selects which status bits may drive the combined SMI request output.

The fast-off timer is a free-running down-counter with a programmable reload value. When it reaches zero it emits a one-cycle expiry pulse and is back at the reload value on the following clock. The expiry pulse sets status bit 5. A pulse on the activity input reloads the timer, so an active system never times out. Writing the reload register also restarts the count from the new value.

Top module: `smi_event_status`

## Requirements
- R1: Reset (synchronous, active high) clears all status bits, the enable mask, the read data and the SMI output to zero. It sets both the reload value and the count to FO_INIT.
- R2: Status bits 15:9 and enable bits 15:9 always read back as 0.
- R3: Status bit positions are fixed: 8 = keyboard emulation, 7 = power-management control write, 6 = external SMI pin, 5 = fast-off expiry, 4 = IRQ12, 3 = IRQ8, 2 = IRQ4, 1 = IRQ3, 0 = IRQ1. A source pulse in cycle N makes its bit read as 1 from the following edge onward. A bit with no event stays 0.
- R4: A status bit stays 1 until a write to address 0 carries a 0 in that bit position. A 1 in the written data leaves the bit unchanged.
- R5: When a source event and a clearing write to the same bit fall in the same cycle, the bit ends up 1.
- R6: The IRQ8 source is active low: bit 3 is set by a cycle with irq8_n = 0, and irq8_n = 1 never sets it.
- R7: smi_o is 1 exactly one cycle after a cycle in which (status AND enable) is non-zero, and 0 otherwise. The enable mask is address 1, bits 8:0, read/write.
- R8: With reload value L, the counter steps L, L-1, ... 0 and then reloads L on the next clock, giving a period of L+1 cycles. Each zero cycle produces one expiry that sets status bit 5.
- R9: An activity pulse reloads the counter from the reload register and suppresses an expiry in that cycle.
- R10: A write to address 2 updates the reload register and loads the counter with the written value at the same edge.
- R11: bus_rdata is registered. It shows, one edge after bus_addr is presented, the selected register as it stood before that edge. The address map is 0 = status, 1 = enable, 2 = reload, 3 = current count. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_kbd | input | 1 | Keyboard-emulation event pulse |
| evt_pmctl | input | 1 | Power-management control write pulse |
| evt_ext | input | 1 | External SMI pin event pulse |
| irq1 | input | 1 | IRQ1 request pulse |
| irq3 | input | 1 | IRQ3 request pulse |
| irq4 | input | 1 | IRQ4 request pulse |
| irq8_n | input | 1 | IRQ8 request, active low |
| irq12 | input | 1 | IRQ12 request pulse |
| fo_activity | input | 1 | Activity pulse that reloads the fast-off timer |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| smi_o | output | 1 | Combined SMI request |

## Verification
Several behaviours are checked by assertions on every cycle: that bits are sticky, that a set wins over a clear, that a bit never sets spontaneously, the timer's restart value after zero, the reload on activity and on a register write, the zero reserved bits in reads, and the one-cycle relation between masked status and smi_o. Other behaviours only show up in the bench's scenarios. These are the bit-to-source mapping, the active-low polarity of IRQ8, the exact L+1 timer period seen through the count register, and the suppression of timeouts by regular activity. The same holds for the read latency and the address map, which the bench checks against its cycle model under random bus traffic.

// File: rtl/smi_stat_pkg.sv
package smi_stat_pkg;
  localparam int NSRC = 9;

  localparam int BIT_IRQ1  = 0;
  localparam int BIT_IRQ3  = 1;
  localparam int BIT_IRQ4  = 2;
  localparam int BIT_IRQ8  = 3;
  localparam int BIT_IRQ12 = 4;
  localparam int BIT_FOFF  = 5;
  localparam int BIT_EXT   = 6;
  localparam int BIT_PMCTL = 7;
  localparam int BIT_KBD   = 8;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_COUNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/smi_fastoff_timer.sv
module smi_fastoff_timer #(
  parameter int          CNT_W   = 16,
  parameter logic [CNT_W-1:0] FO_INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             activity,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire_q
);
  logic at_zero;
  assign at_zero = (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= FO_INIT;
      count_q  <= FO_INIT;
      expire_q <= 1'b0;
    end else begin
      expire_q <= at_zero && !activity && !load_we;
      if (load_we) begin
        reload_q <= load_val;
        count_q  <= load_val;
      end else if (activity || at_zero) begin
        count_q <= reload_q;
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (at_zero && !activity && !load_we) |=> (expire_q && count_q == $past(reload_q)));

  assert_activity_R9: assert property (@(posedge clk) disable iff (rst)
    (activity && !load_we) |=> (!expire_q && count_q == $past(reload_q)));

  assert_load_R10: assert property (@(posedge clk) disable iff (rst)
    load_we |=> (count_q == $past(load_val) && reload_q == $past(load_val)));
endmodule

// File: rtl/smi_status_bank.sv
module smi_status_bank #(
  parameter int NSRC = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] status_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            status_o[g] <= 1'b0;
      else if (set_i[g])  status_o[g] <= 1'b1;
      else if (clr_i[g])  status_o[g] <= 1'b0;
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> status_o[g]);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      (status_o[g] && !clr_i[g]) |=> status_o[g]);

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !set_i[g]) |=> !status_o[g]);

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
      (!status_o[g] && !set_i[g]) |=> !status_o[g]);
  end
endmodule

// File: rtl/smi_regbus.sv
module smi_regbus
  import smi_stat_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NBITS  = 9,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NBITS-1:0]  status_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [NBITS-1:0]  clr_o,
  output logic [NBITS-1:0]  enable_q,
  output logic              reload_we_o,
  output logic [CNT_W-1:0]  reload_val_o,
  output logic [DATA_W-1:0] rdata_q
);
  reg_sel_e sel;
  logic [DATA_W-1:0] rd_mux;

  assign sel          = reg_sel_e'(bus_addr);
  assign clr_o        = (bus_wr && sel == SEL_STATUS) ? ~bus_wdata[NBITS-1:0] : '0;
  assign reload_we_o  = bus_wr && (sel == SEL_RELOAD);
  assign reload_val_o = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) enable_q <= '0;
    else if (bus_wr && sel == SEL_ENABLE) enable_q <= bus_wdata[NBITS-1:0];
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_STATUS: rd_mux[NBITS-1:0] = status_i;
      SEL_ENABLE: rd_mux[NBITS-1:0] = enable_q;
      SEL_RELOAD: rd_mux[CNT_W-1:0] = reload_i;
      SEL_COUNT:  rd_mux[CNT_W-1:0] = count_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) inside {2'd0, 2'd1} && !$past(rst)) |-> (rdata_q[DATA_W-1:NBITS] == '0));
endmodule

// File: rtl/smi_event_status.sv
module smi_event_status
  import smi_stat_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter logic [CNT_W-1:0] FO_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_kbd,
  input  logic              evt_pmctl,
  input  logic              evt_ext,
  input  logic              irq1,
  input  logic              irq3,
  input  logic              irq4,
  input  logic              irq8_n,
  input  logic              irq12,
  input  logic              fo_activity,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              smi_o
);
  logic [NSRC-1:0]  set_vec, clr_vec, status, enable;
  logic [CNT_W-1:0] reload, count, reload_val;
  logic             reload_we, expire;

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_IRQ1]  = irq1;
    set_vec[BIT_IRQ3]  = irq3;
    set_vec[BIT_IRQ4]  = irq4;
    set_vec[BIT_IRQ8]  = !irq8_n;
    set_vec[BIT_IRQ12] = irq12;
    set_vec[BIT_FOFF]  = expire;
    set_vec[BIT_EXT]   = evt_ext;
    set_vec[BIT_PMCTL] = evt_pmctl;
    set_vec[BIT_KBD]   = evt_kbd;
  end

  smi_fastoff_timer #(.CNT_W(CNT_W), .FO_INIT(FO_INIT)) u_timer (
    .clk(clk), .rst(rst), .activity(fo_activity),
    .load_we(reload_we), .load_val(reload_val),
    .reload_q(reload), .count_q(count), .expire_q(expire)
  );

  smi_status_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .status_o(status)
  );

  smi_regbus #(.DATA_W(DATA_W), .NBITS(NSRC), .CNT_W(CNT_W)) u_bus (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status_i(status), .reload_i(reload), .count_i(count),
    .clr_o(clr_vec), .enable_q(enable), .reload_we_o(reload_we),
    .reload_val_o(reload_val), .rdata_q(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) smi_o <= 1'b0;
    else     smi_o <= |(status & enable);
  end

  assert_smi_high_R7: assert property (@(posedge clk) disable iff (rst)
    (|(status & enable)) |=> smi_o);

  assert_smi_low_R7: assert property (@(posedge clk) disable iff (rst)
    !(|(status & enable)) |=> !smi_o);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (status == '0 && enable == '0 && !smi_o && bus_rdata == '0));
endmodule

// File: tb/smi_event_status_tb_top.sv
`timescale 1ns/1ps
module smi_event_status_tb_top;
  localparam logic [15:0] FO_INIT = 16'hFFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic evt_kbd = 0, evt_pmctl = 0, evt_ext = 0, irq1 = 0, irq3 = 0, irq4 = 0;
  logic irq8_n = 1, irq12 = 0, fo_activity = 0, bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        smi_o;

  int checks = 0, fails = 0;

  logic [8:0]  m_st, m_en;
  logic [15:0] m_rl, m_cnt, m_rd;
  logic        m_smi, m_exp;

  always #2.5 clk = ~clk;

  smi_event_status #(.DATA_W(16), .CNT_W(16), .FO_INIT(FO_INIT)) dut_i (
    .clk(clk), .rst(rst), .evt_kbd(evt_kbd), .evt_pmctl(evt_pmctl), .evt_ext(evt_ext),
    .irq1(irq1), .irq3(irq3), .irq4(irq4), .irq8_n(irq8_n), .irq12(irq12),
    .fo_activity(fo_activity), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smi_o(smi_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] src_vec();
    return {evt_kbd, evt_pmctl, evt_ext, m_exp, irq12, ~irq8_n, irq4, irq3, irq1};
  endfunction

  function automatic logic [15:0] sel_read(input logic [1:0] a);
    case (a)
      2'd0: return {7'd0, m_st};
      2'd1: return {7'd0, m_en};
      2'd2: return m_rl;
      default: return m_cnt;
    endcase
  endfunction

  task automatic model_reset();
    m_st = 0; m_en = 0; m_rl = FO_INIT; m_cnt = FO_INIT; m_rd = 0; m_smi = 0; m_exp = 0;
  endtask

  task automatic model_edge();
    logic [8:0]  clr, set_v;
    logic        rl_we;
    logic [15:0] nrd;
    logic        nsmi, nexp;
    nrd   = sel_read(bus_addr);
    nsmi  = |(m_st & m_en);
    set_v = src_vec();
    clr   = (bus_wr && bus_addr == 2'd0) ? ~bus_wdata[8:0] : 9'd0;
    rl_we = bus_wr && bus_addr == 2'd2;
    nexp  = (m_cnt == 0) && !fo_activity && !rl_we;
    m_st  = set_v | (m_st & ~clr);
    if (bus_wr && bus_addr == 2'd1) m_en = bus_wdata[8:0];
    if (rl_we) begin m_rl = bus_wdata; m_cnt = bus_wdata; end
    else if (fo_activity || m_cnt == 0) m_cnt = m_rl;
    else m_cnt = m_cnt - 1'b1;
    m_rd = nrd; m_smi = nsmi; m_exp = nexp;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R11 rdata", bus_rdata, m_rd);
    chk("R7 smi_o", smi_o, m_smi);
  endtask

  task automatic idle();
    evt_kbd = 0; evt_pmctl = 0; evt_ext = 0; irq1 = 0; irq3 = 0; irq4 = 0;
    irq8_n = 1; irq12 = 0; fo_activity = 0; bus_wr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    idle(); bus_wr = 1; bus_addr = a; bus_wdata = d; step(); idle();
  endtask

  task automatic rd(input logic [1:0] a);
    idle(); bus_addr = a; step();
  endtask

  task automatic pulse(input int b);
    idle();
    case (b)
      0: irq1 = 1; 1: irq3 = 1; 2: irq4 = 1; 3: irq8_n = 0; 4: irq12 = 1;
      6: evt_ext = 1; 7: evt_pmctl = 1; default: evt_kbd = 1;
    endcase
    step(); idle();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0; model_reset();
    // R1: reset state
    chk("R1 rdata after reset", bus_rdata, 16'h0);
    chk("R1 smi after reset", smi_o, 1'b0);
    rd(2'd0); chk("R1 status zero", bus_rdata, 16'h0);
    rd(2'd1); chk("R1 enable zero", bus_rdata, 16'h0);
    rd(2'd2); chk("R1 reload init", bus_rdata, FO_INIT);

    // R10: reload write loads counter
    wr(2'd2, 16'hFFF0);
    rd(2'd2); chk("R10 reload reg", bus_rdata, 16'hFFF0);
    wr(2'd2, 16'hFFFF);
    rd(2'd3); chk("R10 count loaded", bus_rdata, 16'hFFFF);

    // R3 / R6: bit mapping per source
    for (int b = 0; b < 9; b++) begin
      if (b == 5) continue;
      pulse(b);
      rd(2'd0); chk(b == 3 ? "R6 irq8 low sets bit3" : "R3 bit map", bus_rdata, 16'(1 << b));
      wr(2'd0, 16'h0000);
      rd(2'd0); chk("R4 clear by zero", bus_rdata, 16'h0);
    end

    // R4: write one keeps bit, write zero clears it
    pulse(0);
    wr(2'd0, 16'hFFFF);
    rd(2'd0); chk("R4 write one keeps", bus_rdata, 16'h0001);
    wr(2'd0, 16'hFFFE);
    rd(2'd0); chk("R4 write zero clears", bus_rdata, 16'h0000);

    // R5: set and clear in the same cycle
    idle(); irq3 = 1; bus_wr = 1; bus_addr = 2'd0; bus_wdata = 16'h0000; step(); idle();
    rd(2'd0); chk("R5 set wins", bus_rdata, 16'h0002);
    wr(2'd0, 16'h0000);

    // R2: reserved bits read zero
    wr(2'd1, 16'hFFFF);
    rd(2'd1); chk("R2 enable reserved", bus_rdata, 16'h01FF);
    wr(2'd0, 16'hFFFF);
    rd(2'd0); chk("R2 status reserved", bus_rdata[15:9], 7'h0);

    // R7: masked SMI request
    wr(2'd1, 16'h0008);
    pulse(2);
    rd(2'd0); rd(2'd0); chk("R7 masked source no smi", smi_o, 1'b0);
    pulse(3);
    chk("R7 smi not yet", smi_o, 1'b0);
    rd(2'd0); chk("R7 smi one cycle after status", smi_o, 1'b1);
    wr(2'd0, 16'h0000);
    chk("R7 smi lags clear", smi_o, 1'b1);
    rd(2'd0); chk("R7 smi drops", smi_o, 1'b0);
    wr(2'd1, 16'h0000);

    // R8: period L+1 and restart
    wr(2'd2, 16'd4);
    for (int k = 1; k <= 11; k++) begin
      rd(2'd3); chk("R8 count sequence", bus_rdata, 16'(4 - ((k - 1) % 5)));
    end
    rd(2'd0); chk("R8 expiry sets bit5", bus_rdata[5], 1'b1);
    wr(2'd0, 16'h0000);

    // R9: activity reload and suppression
    wr(2'd2, 16'd10);
    rd(2'd3); rd(2'd3); rd(2'd3);
    idle(); fo_activity = 1; bus_addr = 2'd3; step(); idle();
    rd(2'd3); chk("R9 activity reloads", bus_rdata, 16'd10);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0000);
    for (int k = 0; k < 24; k++) begin
      idle(); fo_activity = (k % 3 == 2); bus_addr = 2'd0; step();
    end
    idle();
    rd(2'd0); chk("R9 no expiry while active", bus_rdata[5], 1'b0);

    // R11: count register read-only
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'h1234);
    rd(2'd3); chk("R11 count not writable", bus_rdata, 16'hFFFE);

    // random traffic against the cycle model (R3..R11)
    wr(2'd2, 16'd20);
    for (int n = 0; n < 6000; n++) begin
      idle();
      evt_kbd   = ($urandom % 23) == 0;
      evt_pmctl = ($urandom % 29) == 0;
      evt_ext   = ($urandom % 31) == 0;
      irq1      = ($urandom % 17) == 0;
      irq3      = ($urandom % 19) == 0;
      irq4      = ($urandom % 37) == 0;
      irq8_n    = ($urandom % 41) != 0;
      irq12     = ($urandom % 43) == 0;
      fo_activity = ($urandom % 53) == 0;
      bus_addr  = 2'($urandom);
      bus_wr    = ($urandom % 6) == 0;
      bus_wdata = 16'($urandom);
      if (bus_wr && bus_addr == 2'd2) bus_wdata = 16'(3 + $urandom % 60);
      step();
    end
    idle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule